// File: doc/BRIEF.md
# Serial ADC Sample Output Serializer

This block is the output side of a 12-bit sampling converter's serial port. A host frames each transfer by pulling the active-low chip select low and then toggling a serial clock. The block captures the parallel sample word when the frame opens. It keeps the data line released for the opening clock and drives a zero marker bit. It then shifts out the captured word most significant bit first and, if the host keeps clocking, sends the same word again least significant bit first. The line is released again as soon as chip select returns high.

The block runs on a fast local clock. Chip select and the serial clock are brought in through synchronizers and edge detectors, so the data line changes a few local clocks after each serial clock falling edge. A host that samples on serial clock rising edges therefore sees a settled bit. Hosts that clock in whole bytes are served by the second, reversed copy of the word. The data flow is paced entirely by the host's serial clock, so there is no valid/ready handshake and no back-pressure. The high-impedance state is modelled as an output-enable pin beside the data pin.

Top module: `adc_serial_tx`

## Requirements
- R1: The data and enable outputs change only in response to a falling serial clock edge within a frame, or to a chip select change. They stay constant for the whole high phase of the serial clock.
- R2: The sample word is captured when chip select falls. Changes on the sample input later in the same frame do not alter the bits sent.
- R3: The enable output stays 0 until the second counted falling edge. On that edge the enable goes to 1 and the data output is 0 (the marker bit).
- R4: On counted falling edges 3 through 14, the data output carries sample bits 11 down to 0, one bit per edge.
- R5: On counted falling edges 15 through 25, the data output carries sample bits 1 up to 11, one bit per edge. A host sampling on rising edges therefore gets bit 0 once, followed by the word in ascending order.
- R6: From counted falling edge 26 until chip select rises, the enable output stays 1 and the data output stays 0. The edge counter saturates and does not wrap.
- R7: While chip select is high, the enable and data outputs are 0 and the edge counter is cleared. Every new frame restarts from the beginning of the sequence.
- R8: A falling edge is counted only after at least one rising serial clock edge has occurred in the frame. The sequence a rising-edge host sees is therefore the same whether the serial clock idles low or high when chip select falls.
- R9: After reset, the enable and data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sample | input | DATA_W | Parallel sample word from the converter |
| dout | output | 1 | Serial data toward the host |
| dout_oe | output | 1 | Drive enable for dout; 0 means the line is released |

## Verification
The assertions assume that each serial clock phase and the chip select setup time span more local clocks than the synchronizer and output register latency. Under that assumption, the edge counter never sees two serial edges merged and a falling edge is never missed. They also assume the sample word is stable while chip select falls. The stimulus holds every serial clock phase for six local clocks and changes the sample word only well away from the chip select edge. It then checks the output at both ends of every high phase, which is where a host samples.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  // Output phases of a frame, derived from the falling-edge count.
  typedef enum logic [2:0] {
    PH_QUIET  = 3'd0,
    PH_MARK   = 3'd1,
    PH_DESC   = 3'd2,
    PH_ASC    = 3'd3,
    PH_TAIL   = 3'd4
  } ser_phase_e;

  // Classify a falling-edge count into a phase.
  function automatic ser_phase_e phase_of(input int cnt, input int quiet, input int width);
    if (cnt <= quiet)                      return PH_QUIET;
    else if (cnt == quiet + 1)             return PH_MARK;
    else if (cnt <= quiet + 1 + width)     return PH_DESC;
    else if (cnt <= quiet + 2 * width)     return PH_ASC;
    else                                   return PH_TAIL;
  endfunction

endpackage

// File: rtl/adc_ser_edge_sync.sv
module adc_ser_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {DEPTH{RST_VAL}};
    else        pipe_q <= {pipe_q[DEPTH-2:0], din};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] &  pipe_q[STAGES];

endmodule

// File: rtl/adc_ser_frame_ctrl.sv
module adc_ser_frame_ctrl #(
  parameter int DATA_W = 12,
  parameter int QUIET  = 1,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_low_i,
  input  logic              cs_fall_i,
  input  logic              sclk_lvl_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o
);

  // Count at which the sequence ends and the counter saturates.
  localparam int CNT_MAX = QUIET + 1 + 2 * DATA_W;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

  logic [DATA_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cs_fall_i) word_q <= sample_i;
      if (!cs_low_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        if (sclk_rise_i) armed_q <= 1'b1;
        if (sclk_fall_i && armed_q && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign word_o = word_q;
  assign cnt_o  = cnt_q;

  AST_CNT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low_i && !sclk_fall_i) |=> $stable(cnt_q)); // R1
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low_i && !cs_fall_i) |=> $stable(word_q)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP); // R6
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low_i |=> (cnt_q == '0)); // R7
  AST_UNARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low_i && !armed_q) |=> $stable(cnt_q)); // R8
  AST_ARM_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> sclk_lvl_i); // R8

endmodule

// File: rtl/adc_ser_bit_select.sv
module adc_ser_bit_select
  import adc_ser_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int QUIET  = 1,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_low_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              dout_o,
  output logic              dout_oe_o
);

  localparam int MARK_POS  = QUIET + 1;
  localparam int LAST_DESC = MARK_POS + DATA_W;
  localparam int IDX_W     = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  ser_phase_e       phase;
  logic [IDX_W-1:0] idx;
  logic             bit_nxt;
  logic             oe_nxt;
  logic             dout_q;
  logic             oe_q;

  always_comb begin
    phase   = phase_of(int'(cnt_i), QUIET, DATA_W);
    idx     = '0;
    bit_nxt = 1'b0;
    unique case (phase)
      PH_DESC: begin
        idx     = IDX_W'(LAST_DESC - int'(cnt_i));
        bit_nxt = word_i[idx];
      end
      PH_ASC: begin
        idx     = IDX_W'(int'(cnt_i) - LAST_DESC);
        bit_nxt = word_i[idx];
      end
      default: bit_nxt = 1'b0;
    endcase
    oe_nxt = cs_low_i && (phase != PH_QUIET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      oe_q   <= oe_nxt;
      dout_q <= oe_nxt & bit_nxt;
    end
  end

  assign dout_o    = dout_q;
  assign dout_oe_o = oe_q;

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low_i && int'(cnt_i) <= QUIET) |=> !dout_oe_o); // R3
  AST_MARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low_i && int'(cnt_i) == MARK_POS) |=> (dout_oe_o && !dout_o)); // R3
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low_i && int'(cnt_i) == LAST_DESC + DATA_W) |=> (dout_oe_o && !dout_o)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low_i |=> (!dout_oe_o && !dout_o)); // R7

endmodule

// File: rtl/adc_serial_tx.sv
module adc_serial_tx #(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int QUIET       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample,
  output logic              dout,
  output logic              dout_oe
);

  localparam int CNT_MAX = QUIET + 1 + 2 * DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              cs_lvl, cs_rise, cs_fall;
  logic              sclk_lvl, sclk_rise, sclk_fall;
  logic [DATA_W-1:0] word;
  logic [CNT_W-1:0]  cnt;

  adc_ser_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .din(cs_n),
    .level_o(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  adc_ser_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk),
    .level_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  adc_ser_frame_ctrl #(.DATA_W(DATA_W), .QUIET(QUIET), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_low_i(~cs_lvl), .cs_fall_i(cs_fall),
    .sclk_lvl_i(sclk_lvl), .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .sample_i(sample), .word_o(word), .cnt_o(cnt)
  );

  adc_ser_bit_select #(.DATA_W(DATA_W), .QUIET(QUIET), .CNT_W(CNT_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .cs_low_i(~cs_lvl),
    .word_i(word), .cnt_i(cnt),
    .dout_o(dout), .dout_oe_o(dout_oe)
  );

  AST_RELEASE_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !dout_oe); // R7
  AST_OUT_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_rise && !cs_fall && !$past(sclk_fall)) |=> $stable(dout)); // R1

endmodule

// File: tb/adc_serial_tx_bench.sv
module adc_serial_tx_bench;

  localparam int W = 12;
  localparam int H = 6;  // local clocks per serial clock phase

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic [W-1:0] sample = '0;
  logic         dout;
  logic         dout_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  adc_serial_tx u_adc_serial_tx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sample(sample), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected {oe, dout} after c counted falling edges.
  function automatic logic [1:0] expv(input int c, input logic [W-1:0] w);
    if (c < 2)        return 2'b00;
    else if (c == 2)  return 2'b10;
    else if (c <= 14) return {1'b1, w[14 - c]};
    else if (c <= 25) return {1'b1, w[c - 14]};
    else              return 2'b10;
  endfunction

  function automatic string req_of(input int c, input bit hi);
    string r;
    if (c <= 2)       r = "R3";
    else if (c <= 14) r = "R4";
    else if (c <= 25) r = "R5";
    else              r = "R6";
    if (hi) r = {r, "/R8"};
    return r;
  endfunction

  task automatic run_frame(input logic [W-1:0] w, input bit idle_hi, input int nclk);
    logic [W-1:0] msb_word;
    logic [W-1:0] lsb_word;
    logic [1:0]   e;
    msb_word = '0;
    lsb_word = '0;
    sclk = idle_hi;
    sample = w;
    tick(H);
    cs_n = 1'b0;
    tick(3);
    sample = ~w ^ 12'h5A5;  // R2: later changes must not be sent
    tick(H);
    if (idle_hi) begin
      sclk = 1'b0;
      tick(H);
    end
    for (int i = 1; i <= nclk; i++) begin
      e = expv(i - 1, w);
      chk({dout_oe, dout} == e, req_of(i - 1, idle_hi), W'({dout_oe, dout}), W'(e));
      if (i >= 4 && i <= 15) msb_word[15 - i] = dout;
      if (i >= 15 && i <= 26) lsb_word[i - 15] = dout;
      sclk = 1'b1;
      tick(H);
      chk({dout_oe, dout} == e, "R1", W'({dout_oe, dout}), W'(e));
      sclk = 1'b0;
      tick(H);
    end
    if (nclk >= 15) chk(msb_word == w, "R4/R2", msb_word, w);
    if (nclk >= 26) chk(lsb_word == w, "R5/R2", lsb_word, w);
    if (idle_hi) sclk = 1'b1;
    tick(H);
    cs_n = 1'b1;
    tick(8);
    chk({dout_oe, dout} == 2'b00, "R7", W'({dout_oe, dout}), '0);
  endtask

  initial begin
    tick(3);
    chk({dout_oe, dout} == 2'b00, "R9", W'({dout_oe, dout}), '0);
    rst_n = 1'b1;
    tick(4);
    chk({dout_oe, dout} == 2'b00, "R9", W'({dout_oe, dout}), '0);
    for (int m = 0; m < 2; m++) begin
      run_frame(12'h000, bit'(m), 30);
      run_frame(12'hFFF, bit'(m), 30);
      run_frame(12'hA5A, bit'(m), 30);
      run_frame(12'h5A5, bit'(m), 30);
      run_frame(12'h123, bit'(m), 30);
      run_frame(12'hC3E, bit'(m), 16);
      run_frame(12'h7B1, bit'(m), 26);
      for (int b = 0; b < W; b++) run_frame(W'(1) << b, bit'(m), 28);
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule